// File: doc/BRIEF.md
# Banked GPIO Register Interface

This block is the register file of a 128-pin general-purpose I/O controller. The pins form four banks of 32, and pin n lives in bank n/32 at bit n mod 32. A simple synchronous register bus gives software access to each bank's state: a read/write direction word, an output latch that only changes through separate write-only set and clear ports, a read-only level view, and two plain alternate-function storage words. The block drives a data value and an output-enable for every pin. It also sends out a one-cycle notify pulse on each level read, so a neighbouring model or sampler can react to software polling the pins.

The edge-detect enable and status offsets sit inside this block's address window, but a separate edge/interrupt block owns them. Here they read as zero, ignore writes and are not flagged as errors. Any other hole below offset 0x200, including an address that is not word aligned, reads as zero, ignores the write and raises a one-cycle error pulse. Anything at 0x200 or above is silently ignored. Banks 0 to 2 are interleaved at a word stride inside each register group. Bank 3's copy of each group sits 0x100 higher, so the decoder must not treat it as a fourth interleaved entry.

Top module: `gpio_bank_regfile`

## Requirements
- R1: While reset is held and on the first cycle after it, every direction bit, latch bit and alternate-function word is zero. Every pin_oe and pin_out bit is 0, and bus_rdata is 0.
- R2: The direction word of bank b (b=0..2) is at 0x00C+4b, and bank 3's is at 0x10C. A bit value of 1 makes the pin an output. The word reads back what was written, and pin_oe shows it from the clock edge that takes the write.
- R3: A write to the set port (0x018+4b, bank 3 at 0x118) ORs the data into the latch. A write to the clear port (0x024+4b, bank 3 at 0x124) clears each latch bit whose data bit is 1. No other access changes the latch.
- R4: A read of a set or clear port returns zero.
- R5: A read of the level word (0x000+4b, bank 3 at 0x100) returns latch bits where direction is 1 and registered pin_in bits where direction is 0. Each such read gives lvl_rd_pulse high for exactly one cycle, and no other read does.
- R6: pin_out equals latch AND direction for every pin. A write that changes either one updates pin_out on the same clock edge as pin_oe.
- R7: Bank k's lower alternate-function word is at 0x054+8k and its upper word is at 0x058+8k. Both are plain read/write storage.
- R8: Offsets of 0x200 and above read as zero, ignore writes and give no error pulse. This includes aliases of mapped offsets, such as 0x20C.
- R9: Any other offset below 0x200 that is not mapped (including non-word-aligned addresses) reads as zero and ignores writes. It gives bad_addr_pulse high for one cycle.
- R10: The edge-detect offsets (0x030, 0x03C and 0x048 groups at +4b, and bank 3 at 0x130, 0x13C, 0x148) read as zero, ignore writes and give no error pulse.
- R11: Pin n maps to bank n/32, bit n mod 32, on pin_in, pin_out and pin_oe. For example, pin 100 is bank 3, bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Byte offset of the access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_re, else zero |
| pin_in | input | 128 | Pin input levels |
| pin_out | output | 128 | Driven pin values |
| pin_oe | output | 128 | Pin output enables |
| lvl_rd_pulse | output | 1 | One-cycle pulse after a level read |
| bad_addr_pulse | output | 1 | One-cycle pulse after an unmapped access below 0x200 |

## Verification
A write takes effect on the clock edge that samples bus_we, so pin_out, pin_oe and any later readback show the new state one cycle after the write is presented. bus_rdata, lvl_rd_pulse and bad_addr_pulse are registered and appear exactly one cycle after the access. The pulses drop again on the following cycle. pin_in goes through one register before it reaches the level word, so it must change at least one edge before the read is sampled. The bench drives on falling edges, samples at the next falling edge after the access edge, and checks pulse fall-off one cycle later.

// File: rtl/gpio_bank_pkg.sv
// Package: shared sizes, address-map constants and register-select types
// for the banked GPIO register file. Assumes four banks; bank 3 sits in a
// separate window above the interleaved banks 0..2.
package gpio_bank_pkg;

    localparam int NUM_BANKS      = 4;
    localparam int PINS_PER_BANK  = 32;
    localparam int NUM_PINS       = NUM_BANKS * PINS_PER_BANK;
    localparam int ADDR_W         = 12;
    localparam int DATA_W         = 32;
    localparam int BANK_W         = $clog2(NUM_BANKS);

    // Banks 0..NUM_BANKS-2 interleave inside a group; the last one lives apart.
    localparam int NEAR_BANKS      = NUM_BANKS - 1;
    localparam int GROUP_STRIDE    = 4 * NEAR_BANKS;
    localparam int NUM_GROUPS      = 7;
    localparam int ALT_BASE        = NUM_GROUPS * GROUP_STRIDE;
    localparam int ALT_PAIR_STRIDE = 8;
    localparam int FAR_BANK_OFS    = 'h100;
    localparam int WINDOW_END      = 'h200;

    typedef enum logic [3:0] {
        K_UNMAPPED,
        K_LEVEL,
        K_DIR,
        K_SET,
        K_CLR,
        K_EDGE,
        K_ALT_LO,
        K_ALT_HI,
        K_FAR
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e           kind;
        logic [BANK_W-1:0]   bank;
    } reg_sel_t;

    // Register kind of each group, in address order (order fixes the map).
    function automatic reg_kind_e group_kind(input int g);
        case (g)
            0:       return K_LEVEL;
            1:       return K_DIR;
            2:       return K_SET;
            3:       return K_CLR;
            default: return K_EDGE;
        endcase
    endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
// Module: byte offset -> register kind and bank. Purely combinational.
// Assumes word accesses; a misaligned offset inside the window is unmapped.
module gpio_addr_decode
    import gpio_bank_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] addr,
    output reg_sel_t      sel
);

    // Match the offset against every group slot and alternate-function word.
    always_comb begin
        sel = '{kind: K_UNMAPPED, bank: '0};
        if (int'(addr) >= WINDOW_END) begin
            sel.kind = K_FAR;
        end else if (addr[1:0] == 2'b00) begin
            if (int'(addr) < FAR_BANK_OFS) begin
                for (int g = 0; g < NUM_GROUPS; g++) begin
                    for (int b = 0; b < NEAR_BANKS; b++) begin
                        if (int'(addr) == g * GROUP_STRIDE + 4 * b) begin
                            sel.kind = group_kind(g);
                            sel.bank = BANK_W'(b);
                        end
                    end
                end
                for (int k = 0; k < NUM_BANKS; k++) begin
                    if (int'(addr) == ALT_BASE + ALT_PAIR_STRIDE * k) begin
                        sel.kind = K_ALT_LO;
                        sel.bank = BANK_W'(k);
                    end
                    if (int'(addr) == ALT_BASE + ALT_PAIR_STRIDE * k + 4) begin
                        sel.kind = K_ALT_HI;
                        sel.bank = BANK_W'(k);
                    end
                end
            end else begin
                for (int g = 0; g < NUM_GROUPS; g++) begin
                    if (int'(addr) == FAR_BANK_OFS + g * GROUP_STRIDE) begin
                        sel.kind = group_kind(g);
                        sel.bank = BANK_W'(NUM_BANKS - 1);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/gpio_bank.sv
// Module: state of one 32-pin bank: direction, output latch, two
// alternate-function words and a registered sample of the pin inputs.
// Assumes at most one write strobe is active per cycle.
module gpio_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] wdata,
    input  logic         wr_dir,
    input  logic         wr_set,
    input  logic         wr_clr,
    input  logic         wr_alt_lo,
    input  logic         wr_alt_hi,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] alt_lo_q,
    output logic [W-1:0] alt_hi_q,
    output logic [W-1:0] level,
    output logic [W-1:0] drv
);

    logic [W-1:0] latch_q;
    logic [W-1:0] in_smp_q;

    // Direction word: plain read/write.
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= '0;
        else if (wr_dir) dir_q <= wdata;
    end

    // Output latch: changed only by the set and clear ports.
    always_ff @(posedge clk) begin
        if (!rst_n)      latch_q <= '0;
        else if (wr_set) latch_q <= latch_q | wdata;
        else if (wr_clr) latch_q <= latch_q & ~wdata;
    end

    // Alternate-function storage words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alt_lo_q <= '0;
            alt_hi_q <= '0;
        end else begin
            if (wr_alt_lo) alt_lo_q <= wdata;
            if (wr_alt_hi) alt_hi_q <= wdata;
        end
    end

    // Input sample register feeding the level view.
    always_ff @(posedge clk) begin
        if (!rst_n) in_smp_q <= '0;
        else        in_smp_q <= pad_in;
    end

    // Driven value and level view.
    always_comb begin
        drv   = latch_q & dir_q;
        level = drv | (in_smp_q & ~dir_q);
    end

    // R3: the latch holds whenever neither set nor clear is written.
    a_r3_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_set || wr_clr) |=> $stable(latch_q));

    // R2: the direction word holds without a direction write.
    a_r2_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dir |=> $stable(dir_q));

endmodule

// File: rtl/gpio_read_mux.sv
// Module: selects the read word for a decoded register. Combinational.
// Write-only, edge-owned, unmapped and far offsets all return zero.
module gpio_read_mux
    import gpio_bank_pkg::*;
#(
    parameter int NB = NUM_BANKS,
    parameter int W  = PINS_PER_BANK
) (
    input  reg_sel_t              sel,
    input  logic [NB-1:0][W-1:0]  level,
    input  logic [NB-1:0][W-1:0]  dir,
    input  logic [NB-1:0][W-1:0]  alt_lo,
    input  logic [NB-1:0][W-1:0]  alt_hi,
    output logic [W-1:0]          rd_word
);

    // Pick the word by register kind, then by bank.
    always_comb begin
        case (sel.kind)
            K_LEVEL:  rd_word = level[sel.bank];
            K_DIR:    rd_word = dir[sel.bank];
            K_ALT_LO: rd_word = alt_lo[sel.bank];
            K_ALT_HI: rd_word = alt_hi[sel.bank];
            default:  rd_word = '0;
        endcase
    end

endmodule

// File: rtl/gpio_bank_regfile.sv
// Module: top of the banked GPIO register file. Decodes bus accesses,
// steers write strobes to the banks, registers read data and the
// level-read and bad-address pulses. Assumes a single-cycle bus with no
// wait states; read data is valid one cycle after bus_re.
module gpio_bank_regfile
    import gpio_bank_pkg::*;
#(
    parameter int NB = NUM_BANKS,
    parameter int W  = PINS_PER_BANK,
    parameter int AW = ADDR_W,
    localparam int NP = NB * W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [W-1:0]  bus_wdata,
    input  logic          bus_re,
    output logic [W-1:0]  bus_rdata,
    input  logic [NP-1:0] pin_in,
    output logic [NP-1:0] pin_out,
    output logic [NP-1:0] pin_oe,
    output logic          lvl_rd_pulse,
    output logic          bad_addr_pulse
);

    reg_sel_t             sel;
    logic [NB-1:0]        we_dir, we_set, we_clr, we_alo, we_ahi;
    logic [NB-1:0][W-1:0] dir_w, alo_w, ahi_w, lvl_w, drv_w;
    logic [NB-1:0][W-1:0] pin_in_w;
    logic [W-1:0]         rd_word;

    gpio_addr_decode #(.AW(AW)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    assign pin_in_w = pin_in;

    generate
        for (genvar b = 0; b < NB; b++) begin : g_bank
            // Per-bank write strobes from the decoded select.
            always_comb begin
                we_dir[b] = bus_we && sel.kind == K_DIR    && int'(sel.bank) == b;
                we_set[b] = bus_we && sel.kind == K_SET    && int'(sel.bank) == b;
                we_clr[b] = bus_we && sel.kind == K_CLR    && int'(sel.bank) == b;
                we_alo[b] = bus_we && sel.kind == K_ALT_LO && int'(sel.bank) == b;
                we_ahi[b] = bus_we && sel.kind == K_ALT_HI && int'(sel.bank) == b;
            end

            gpio_bank #(.W(W)) u_bank (
                .clk       (clk),
                .rst_n     (rst_n),
                .wdata     (bus_wdata),
                .wr_dir    (we_dir[b]),
                .wr_set    (we_set[b]),
                .wr_clr    (we_clr[b]),
                .wr_alt_lo (we_alo[b]),
                .wr_alt_hi (we_ahi[b]),
                .pad_in    (pin_in_w[b]),
                .dir_q     (dir_w[b]),
                .alt_lo_q  (alo_w[b]),
                .alt_hi_q  (ahi_w[b]),
                .level     (lvl_w[b]),
                .drv       (drv_w[b])
            );
        end
    endgenerate

    gpio_read_mux #(.NB(NB), .W(W)) u_rmux (
        .sel     (sel),
        .level   (lvl_w),
        .dir     (dir_w),
        .alt_lo  (alo_w),
        .alt_hi  (ahi_w),
        .rd_word (rd_word)
    );

    // Flatten bank vectors to pins: pin n = bank n/W, bit n%W.
    assign pin_out = drv_w;
    assign pin_oe  = dir_w;

    // Registered read data; zero when no read is made.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_re) bus_rdata <= rd_word;
        else             bus_rdata <= '0;
    end

    // One-cycle notify and error pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_rd_pulse   <= 1'b0;
            bad_addr_pulse <= 1'b0;
        end else begin
            lvl_rd_pulse   <= bus_re && sel.kind == K_LEVEL;
            bad_addr_pulse <= (bus_re || bus_we) && sel.kind == K_UNMAPPED;
        end
    end

    // R3: at most one bank register is written per cycle.
    a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({we_dir, we_set, we_clr, we_alo, we_ahi}));

    // R4: write-only ports read back as zero.
    a_r4_wo_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_re && (sel.kind == K_SET || sel.kind == K_CLR) |=> bus_rdata == '0);

    // R5: the notify pulse only follows a read.
    a_r5_notify_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_rd_pulse |-> $past(bus_re));

    // R8: offsets beyond the window read as zero.
    a_r8_far_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_re && int'(bus_addr) >= WINDOW_END |=> bus_rdata == '0);

    // R9: the error pulse follows an access inside the window.
    a_r9_err_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        bad_addr_pulse |-> $past(bus_re || bus_we) && int'($past(bus_addr)) < WINDOW_END);

endmodule

// File: tb/gpio_bank_regfile_bench.sv
module gpio_bank_regfile_bench;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [11:0]  bus_addr = '0;
    logic         bus_we = 1'b0;
    logic [31:0]  bus_wdata = '0;
    logic         bus_re = 1'b0;
    logic [31:0]  bus_rdata;
    logic [127:0] pin_in = '0;
    logic [127:0] pin_out;
    logic [127:0] pin_oe;
    logic         lvl_rd_pulse;
    logic         bad_addr_pulse;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    logic [31:0] rd;
    logic        note, err;

    always #(CLK_PERIOD / 2) clk = ~clk;

    gpio_bank_regfile u_gpio_bank_regfile (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_addr       (bus_addr),
        .bus_we         (bus_we),
        .bus_wdata      (bus_wdata),
        .bus_re         (bus_re),
        .bus_rdata      (bus_rdata),
        .pin_in         (pin_in),
        .pin_out        (pin_out),
        .pin_oe         (pin_oe),
        .lvl_rd_pulse   (lvl_rd_pulse),
        .bad_addr_pulse (bad_addr_pulse)
    );

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        err = bad_addr_pulse;
        note = lvl_rd_pulse;
    endtask

    task automatic bus_read(input logic [11:0] a);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        rd = bus_rdata;
        err = bad_addr_pulse;
        note = lvl_rd_pulse;
    endtask

    task automatic t_reset();
        check(pin_oe == '0, "R1 pin_oe", pin_oe, 0);
        check(pin_out == '0, "R1 pin_out", pin_out, 0);
        check(bus_rdata == '0, "R1 rdata", bus_rdata, 0);
        bus_read(12'h00C);
        check(rd == 0, "R1 dir0", rd, 0);
        bus_read(12'h070);
        check(rd == 0, "R1 alt3 upper", rd, 0);
    endtask

    task automatic t_dir();
        bus_write(12'h010, 32'hF0F0_0000);
        check(pin_oe[63:32] == 32'hF0F0_0000, "R2 pin_oe bank1", pin_oe[63:32], 32'hF0F0_0000);
        bus_read(12'h010);
        check(rd == 32'hF0F0_0000, "R2 readback bank1", rd, 32'hF0F0_0000);
        check(note == 1'b0, "R5 no notify on dir read", note, 0);
        bus_write(12'h10C, 32'h0000_00A5);
        bus_read(12'h10C);
        check(rd == 32'h0000_00A5, "R2 readback bank3", rd, 32'hA5);
        check(pin_oe[127:96] == 32'hA5, "R2 pin_oe bank3", pin_oe[127:96], 32'hA5);
        bus_write(12'h10C, 32'h0);
    endtask

    task automatic t_set_clr();
        bus_write(12'h01C, 32'h0000_FFFF);
        check(pin_out[63:32] == 32'h0, "R6 masked by dir", pin_out[63:32], 0);
        bus_write(12'h010, 32'hFFFF_FFFF);
        check(pin_out[63:32] == 32'h0000_FFFF, "R6 out follows dir", pin_out[63:32], 32'hFFFF);
        bus_write(12'h028, 32'h0000_00FF);
        check(pin_out[63:32] == 32'h0000_FF00, "R3 clear", pin_out[63:32], 32'hFF00);
        bus_write(12'h01C, 32'h0101_0000);
        check(pin_out[63:32] == 32'h0101_FF00, "R3 set ORs", pin_out[63:32], 32'h0101FF00);
        bus_read(12'h01C);
        check(rd == 0, "R4 set reads zero", rd, 0);
        bus_read(12'h028);
        check(rd == 0, "R4 clear reads zero", rd, 0);
        check(err == 1'b0, "R4 no error", err, 0);
    endtask

    task automatic t_level();
        bus_write(12'h014, 32'h0000_FFFF);
        bus_write(12'h020, 32'h00FF_00FF);
        pin_in[95:64] = 32'hABCD_1234;
        bus_read(12'h008);
        check(rd == 32'hABCD_00FF, "R5 level mix", rd, 32'hABCD00FF);
        check(note == 1'b1, "R5 notify high", note, 1);
        @(negedge clk);
        check(lvl_rd_pulse == 1'b0, "R5 notify one cycle", lvl_rd_pulse, 0);
        bus_read(12'h004);
        check(rd == 32'h0101_FF00, "R5 level outputs", rd, 32'h0101FF00);
    endtask

    task automatic t_pin100();
        pin_in[100] = 1'b1;
        bus_read(12'h100);
        check(rd == 32'h10, "R11 pin 100 input", rd, 32'h10);
        bus_write(12'h10C, 32'h10);
        bus_write(12'h118, 32'h10);
        check(pin_out[100] == 1'b1 && pin_oe[100] == 1'b1, "R11 pin 100 drive",
              {pin_out[100], pin_oe[100]}, 2'b11);
        check(pin_out[127:96] == 32'h10, "R11 bank3 only bit 4", pin_out[127:96], 32'h10);
        bus_write(12'h124, 32'h10);
        check(pin_out[100] == 1'b0, "R3 bank3 clear", pin_out[100], 0);
    endtask

    task automatic t_alt();
        for (int k = 0; k < 4; k++) begin
            bus_write(12'(12'h054 + 8 * k), 32'h1111_0000 * (k + 1));
            bus_write(12'(12'h058 + 8 * k), 32'h0000_2222 * (k + 1));
        end
        for (int k = 0; k < 4; k++) begin
            bus_read(12'(12'h054 + 8 * k));
            check(rd == 32'h1111_0000 * (k + 1), "R7 alt lower", rd, 32'h1111_0000 * (k + 1));
            bus_read(12'(12'h058 + 8 * k));
            check(rd == 32'h0000_2222 * (k + 1), "R7 alt upper", rd, 32'h0000_2222 * (k + 1));
        end
    endtask

    task automatic t_far();
        bus_write(12'h20C, 32'hFFFF_FFFF);
        check(err == 1'b0, "R8 no error on write", err, 0);
        check(pin_oe[31:0] == 32'h0, "R8 alias write ignored", pin_oe[31:0], 0);
        bus_read(12'h20C);
        check(rd == 0, "R8 far reads zero", rd, 0);
        check(err == 1'b0, "R8 no error on read", err, 0);
    endtask

    task automatic t_unmapped();
        bus_write(12'h074, 32'h5);
        check(err == 1'b1, "R9 error on write", err, 1);
        @(negedge clk);
        check(bad_addr_pulse == 1'b0, "R9 error one cycle", bad_addr_pulse, 0);
        bus_write(12'h011, 32'h0);
        check(err == 1'b1, "R9 misaligned error", err, 1);
        check(pin_oe[63:32] == 32'hFFFF_FFFF, "R9 misaligned ignored", pin_oe[63:32], 32'hFFFFFFFF);
        bus_read(12'h1F0);
        check(rd == 0 && err == 1'b1, "R9 read zero with error", {rd, err}, 1);
    endtask

    task automatic t_edge_regs();
        bus_write(12'h030, 32'hFFFF);
        check(err == 1'b0, "R10 no error rise-enable", err, 0);
        bus_read(12'h030);
        check(rd == 0, "R10 rise-enable reads zero", rd, 0);
        bus_write(12'h148, 32'hFFFF_FFFF);
        check(err == 1'b0, "R10 no error bank3 status", err, 0);
        bus_read(12'h13C);
        check(rd == 0 && err == 1'b0, "R10 bank3 fall-enable zero", {rd, err}, 0);
        bus_read(12'h00C);
        check(rd == 0, "R10 writes ignored", rd, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_dir();
        t_set_clr();
        t_level();
        t_pin100();
        t_alt();
        t_far();
        t_unmapped();
        t_edge_regs();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule